// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block converts single internal access requests (data read, instruction fetch, write; byte or word) into bus cycles on a shared address/data bus. Each request first goes through an address decoder. Accesses to the low register window that are not code fetches, and accesses to the on-chip program window while the on-chip program enable is high, are handed to internal memory as a one-clock select pulse. Every other access runs a timed external cycle. The external cycle starts with one address clock and then opens a read or write strobe. It closes with a recovery clock, so the nominal cycle is four clocks long.

The cycle can be stretched in two ways. A configured count forces wait states, and a ready pin holds the cycle until it is seen high. Each wait state adds two clocks. The width of each cycle is chosen on its own. When dynamic width is enabled, the width pin is sampled in the address clock. Otherwise the bus is 8 bits wide. A word access on an 8-bit bus becomes two byte cycles back to back. The address latch output can work as a one-clock latch pulse or as an active-low valid level. The two write outputs can work as write plus high-byte-enable, or as separate low-byte and high-byte write strobes. A fetch indicator is high for the whole of each external fetch cycle. A done pulse returns the assembled read data after the last cycle.

Top module: `ext_bus_ctrl`

## Requirements
- R1: A request is internal when (address <= 00FFh and kind is not fetch) or (2000h <= address <= 3FFFh and `rom_en_i` = 1). An internal request gives `int_sel_o` high for exactly the clock after acceptance. It drives no strobe and gives no `done_o`. Every other request is external. Kind encoding: 0 = data read, 1 = fetch, 2 = write, 3 = data read.
- R2: An external cycle with no waits lasts 4 clocks: address, strobe, strobe, recovery. In latch mode (`cfg_adv_mode_i` = 0), `ale_o` is high only in the address clock, and `ad_o` carries the cycle address there with `ad_oe_o` = 1.
- R3: In valid mode (`cfg_adv_mode_i` = 1), `ale_o` is low from the address clock through the last strobe clock. It is high in the recovery clock and while idle.
- R4: `rd_n_o` is low in the strobe clocks of a read or fetch. `done_o` pulses for one clock, the clock after the last recovery clock, and `rdata_o` is valid from then on. A request is accepted only while `busy_o` is low.
- R5: `cfg_wait_i` = N inserts N wait states of 2 clocks each, whatever the value of `ready_i`.
- R6: After the forced waits, `ready_i` low in the last strobe clock adds another 2-clock wait state. This repeats until `ready_i` is seen high.
- R7: With `cfg_dyn_width_i` = 1, `width_sel_i` sampled in the address clock gives a 16-bit cycle (1) or an 8-bit cycle (0). With `cfg_dyn_width_i` = 0, every cycle is 8-bit.
- R8: A word access on an 8-bit bus runs the even address, then the odd address (address | 1), back to back. The read result is {second byte, first byte}, both taken from `ad_i[7:0]`.
- R9: A 16-bit byte read takes `ad_i[15:8]` for an odd address and `ad_i[7:0]` for an even address, zero-extended. A 16-bit word read returns `ad_i`. An 8-bit byte read returns {00h, `ad_i[7:0]`}.
- R10: With `cfg_split_wr_i` = 0, `wr_n_o` is low in every write strobe clock. `bhe_n_o` is low only when the high lane is written, which is a 16-bit word or a 16-bit odd-address byte.
- R11: With `cfg_split_wr_i` = 1, `wr_n_o` (low-byte write) is low for an even-address byte cycle or a 16-bit word. `bhe_n_o` (high-byte write) is low for an odd-address byte cycle or a 16-bit word.
- R12: `inst_o` is high in every clock of an external fetch cycle and low at all other times.
- R13: In write strobe clocks, `ad_o` carries the full word for a 16-bit word cycle. For a byte cycle it carries the byte on both lanes; the second cycle of a split word uses the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus phase per clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_kind_i | input | 2 | 0 read, 1 fetch, 2 write, 3 read |
| req_addr_i | input | DW | Byte address |
| req_word_i | input | 1 | 1 word access, 0 byte access |
| req_wdata_i | input | DW | Write data (byte in low bits) |
| busy_o | output | 1 | Request in progress |
| int_sel_o | output | 1 | Internal memory select pulse |
| done_o | output | 1 | External access complete pulse |
| rdata_o | output | DW | Assembled read data |
| cfg_dyn_width_i | input | 1 | Enable per-cycle width pin |
| cfg_adv_mode_i | input | 1 | 0 latch pulse, 1 active-low valid |
| cfg_split_wr_i | input | 1 | 0 write+byte-high-enable, 1 split byte writes |
| cfg_wait_i | input | WAIT_W | Forced wait-state count |
| rom_en_i | input | 1 | On-chip program window enable |
| width_sel_i | input | 1 | Bus width pin, 1 = 16-bit |
| ready_i | input | 1 | Ready pin, low stretches cycle |
| ad_i | input | DW | Bus read value |
| ad_o | output | DW | Bus drive value |
| ad_oe_o | output | 1 | Bus drive enable |
| ale_o | output | 1 | Address latch pulse / valid level |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write / low-byte write, active low |
| bhe_n_o | output | 1 | High-byte enable / high-byte write, active low |
| inst_o | output | 1 | Fetch indicator |

## Verification
The request is driven at a falling edge and accepted at the next rising edge. Counting from that acceptance, the address clock is clock 1, the strobes are clocks 2 and 3, and recovery is clock 4. `done_o` is due at clock 5 + 2W for W wait states, and at clock 9 for an 8-bit word. An internal select is due at clock 1. The bench samples every output at each falling edge after acceptance. It tallies strobe, latch and fetch-indicator clocks, records the address-phase and write-phase bus values, and compares the clock of `done_o` with that count. Ready is changed only at falling edges, keyed to the same clock index, so the strobe clock where ready is sampled is known exactly.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INT, ST_ADDR, ST_STRB, ST_HOLD, ST_WT0, ST_WT1, ST_END
  } ebc_state_e;

  localparam logic [1:0] KIND_FETCH = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;
endpackage

// File: rtl/ebc_route.sv
module ebc_route #(
  parameter int          DW       = 16,
  parameter logic [DW-1:0] REGS_TOP = 16'h00FF,
  parameter logic [DW-1:0] ROM_LO   = 16'h2000,
  parameter logic [DW-1:0] ROM_HI   = 16'h3FFF
) (
  input  logic [DW-1:0] addr_i,
  input  logic          fetch_i,
  input  logic          rom_en_i,
  output logic          internal_o
);
  logic in_regs, in_rom;

  always_comb begin
    in_regs    = (addr_i <= REGS_TOP) && !fetch_i;  // code there always goes out
    in_rom     = rom_en_i && (addr_i >= ROM_LO) && (addr_i <= ROM_HI);
    internal_o = in_regs || in_rom;
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int DW     = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [DW-1:0]     req_addr_i,
  input  logic              req_word_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic              req_internal_i,
  input  logic              cfg_dyn_width_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              width_sel_i,
  input  logic              ready_i,
  output ebc_state_e        state_o,
  output logic [1:0]        kind_o,
  output logic [DW-1:0]     cyc_addr_o,
  output logic              word_o,
  output logic              wide_o,
  output logic              second_o,
  output logic [DW-1:0]     wdata_o,
  output logic              capture_o,
  output logic              done_o
);
  ebc_state_e        state_q;
  logic [1:0]        kind_q;
  logic [DW-1:0]     addr_q, wdata_q;
  logic              word_q, wide_q, second_q, done_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic              forced, wait_more, decide;

  always_comb begin
    forced     = wcnt_q < cfg_wait_i;
    wait_more  = forced || !ready_i;
    decide     = (state_q == ST_HOLD) || (state_q == ST_WT1);
    capture_o  = decide && !wait_more && (kind_q != KIND_WRITE);
    cyc_addr_o = second_q ? (addr_q | DW'(1)) :
                 (word_q ? (addr_q & ~DW'(1)) : addr_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_q   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      word_q   <= 1'b0;
      wide_q   <= 1'b0;
      second_q <= 1'b0;
      done_q   <= 1'b0;
      wcnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          kind_q   <= req_kind_i;
          addr_q   <= req_addr_i;
          word_q   <= req_word_i;
          wdata_q  <= req_wdata_i;
          second_q <= 1'b0;
          state_q  <= req_internal_i ? ST_INT : ST_ADDR;
        end
        ST_INT:  state_q <= ST_IDLE;
        ST_ADDR: begin
          wide_q  <= cfg_dyn_width_i && width_sel_i && !second_q;
          wcnt_q  <= '0;
          state_q <= ST_STRB;
        end
        ST_STRB: state_q <= ST_HOLD;
        ST_HOLD, ST_WT1: begin
          if (forced) wcnt_q <= wcnt_q + WAIT_W'(1);
          state_q <= wait_more ? ST_WT0 : ST_END;
        end
        ST_WT0:  state_q <= ST_WT1;
        ST_END: begin
          if (word_q && !wide_q && !second_q) begin
            second_q <= 1'b1;
            state_q  <= ST_ADDR;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign kind_o   = kind_q;
  assign word_o   = word_q;
  assign wide_o   = wide_q;
  assign second_o = second_q;
  assign wdata_o  = wdata_q;
  assign done_o   = done_q;
endmodule

// File: rtl/ebc_lanes.sv
module ebc_lanes
  import ebc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ebc_state_e    state_i,
  input  logic [1:0]    kind_i,
  input  logic [DW-1:0] cyc_addr_i,
  input  logic          word_i,
  input  logic          wide_i,
  input  logic          second_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          capture_i,
  input  logic          cfg_adv_mode_i,
  input  logic          cfg_split_wr_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          ale_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          bhe_n_o,
  output logic          inst_o,
  output logic [DW-1:0] rdata_o
);
  localparam int BW = DW / 2;

  logic          ext, strb, is_wr, full, lo_sel, hi_sel, hi_lane;
  logic [BW-1:0] byte_val;
  logic [DW-1:0] rdata_q;

  always_comb begin
    ext      = (state_i != ST_IDLE) && (state_i != ST_INT);
    strb     = (state_i == ST_STRB) || (state_i == ST_HOLD) ||
               (state_i == ST_WT0)  || (state_i == ST_WT1);
    is_wr    = kind_i == KIND_WRITE;
    full     = wide_i && word_i;
    lo_sel   = full || !cyc_addr_i[0];
    hi_sel   = full || cyc_addr_i[0];
    hi_lane  = wide_i && hi_sel;
    byte_val = second_i ? wdata_i[DW-1:BW] : wdata_i[BW-1:0];

    ale_o   = cfg_adv_mode_i ? !(ext && state_i != ST_END) : (state_i == ST_ADDR);
    ad_oe_o = (state_i == ST_ADDR) || (is_wr && strb);
    if (state_i == ST_ADDR)  ad_o = cyc_addr_i;
    else if (!ad_oe_o)       ad_o = '0;
    else if (full)           ad_o = wdata_i;
    else                     ad_o = {byte_val, byte_val};

    rd_n_o  = !(strb && !is_wr);
    wr_n_o  = !(strb && is_wr && (!cfg_split_wr_i || lo_sel));
    bhe_n_o = !(strb && is_wr && (cfg_split_wr_i ? hi_sel : hi_lane));
    inst_o  = ext && (kind_i == KIND_FETCH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (capture_i) begin
      if (full)               rdata_q <= ad_i;
      else if (wide_i)        rdata_q <= {{BW{1'b0}}, cyc_addr_i[0] ? ad_i[DW-1:BW] : ad_i[BW-1:0]};
      else if (second_i)      rdata_q[DW-1:BW] <= ad_i[BW-1:0];
      else                    rdata_q <= {{BW{1'b0}}, ad_i[BW-1:0]};
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int DW     = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [DW-1:0]     req_addr_i,
  input  logic              req_word_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              busy_o,
  output logic              int_sel_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  input  logic              cfg_dyn_width_i,
  input  logic              cfg_adv_mode_i,
  input  logic              cfg_split_wr_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              rom_en_i,
  input  logic              width_sel_i,
  input  logic              ready_i,
  input  logic [DW-1:0]     ad_i,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              bhe_n_o,
  output logic              inst_o
);
  ebc_state_e    state;
  logic [1:0]    kind;
  logic [DW-1:0] cyc_addr, wdata;
  logic          word, wide, second, capture, req_internal;

  ebc_route #(.DW(DW)) u_route (
    .addr_i     (req_addr_i),
    .fetch_i    (req_kind_i == KIND_FETCH),
    .rom_en_i   (rom_en_i),
    .internal_o (req_internal)
  );

  ebc_seq #(.DW(DW), .WAIT_W(WAIT_W)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_kind_i, .req_addr_i, .req_word_i,
    .req_wdata_i,
    .req_internal_i  (req_internal),
    .cfg_dyn_width_i, .cfg_wait_i, .width_sel_i, .ready_i,
    .state_o    (state),
    .kind_o     (kind),
    .cyc_addr_o (cyc_addr),
    .word_o     (word),
    .wide_o     (wide),
    .second_o   (second),
    .wdata_o    (wdata),
    .capture_o  (capture),
    .done_o     (done_o)
  );

  ebc_lanes #(.DW(DW)) u_lanes (
    .clk_i, .rst_ni,
    .state_i    (state),
    .kind_i     (kind),
    .cyc_addr_i (cyc_addr),
    .word_i     (word),
    .wide_i     (wide),
    .second_i   (second),
    .wdata_i    (wdata),
    .capture_i  (capture),
    .cfg_adv_mode_i, .cfg_split_wr_i, .ad_i, .ad_o, .ad_oe_o, .ale_o,
    .rd_n_o, .wr_n_o, .bhe_n_o, .inst_o, .rdata_o
  );

  assign busy_o    = state != ST_IDLE;
  assign int_sel_o = state == ST_INT;
endmodule

// File: rtl/ext_bus_ctrl_chk.sv
module ext_bus_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_adv_mode_i,
  input logic cfg_split_wr_i,
  input logic busy_o,
  input logic int_sel_o,
  input logic done_o,
  input logic ad_oe_o,
  input logic ale_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic bhe_n_o,
  input logic inst_o
);
  a_r2_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_adv_mode_i && ale_o) |=> !ale_o);

  a_r4_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r4_addr_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_n_o) |-> $past(ad_oe_o));

  a_r1_int_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sel_o |-> (rd_n_o && wr_n_o && bhe_n_o && !inst_o));

  a_r12_no_inst_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_o |-> (wr_n_o && bhe_n_o));

  a_r10_bhe_with_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_split_wr_i && !bhe_n_o) |-> !wr_n_o);
endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk u_chk (.*);

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_word = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy, int_sel, done;
  logic [15:0] rdata;
  logic        cfg_dyn = 1'b1, cfg_adv = 1'b0, cfg_split = 1'b0, rom_en = 1'b1;
  logic [1:0]  cfg_wait = '0;
  logic        width_sel = 1'b1, ready = 1'b1;
  logic [15:0] ad_in, ad_out, lat = '0;
  logic        ad_oe, ale, rd_n, wr_n, bhe_n, inst;

  int n_chk = 0, n_err = 0;
  int done_t, int_t, n_ale, n_alelo, n_rd, n_wr, n_bhe, n_inst, n_aph, ready_rise = 0;
  logic [15:0] aph_addr [2];
  logic [15:0] wdat [2];
  logic [15:0] rd_val;

  always #2 clk = ~clk;

  ext_bus_ctrl u_ext_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_word_i(req_word), .req_wdata_i(req_wdata),
    .busy_o(busy), .int_sel_o(int_sel), .done_o(done), .rdata_o(rdata),
    .cfg_dyn_width_i(cfg_dyn), .cfg_adv_mode_i(cfg_adv), .cfg_split_wr_i(cfg_split),
    .cfg_wait_i(cfg_wait), .rom_en_i(rom_en), .width_sel_i(width_sel), .ready_i(ready),
    .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe), .ale_o(ale), .rd_n_o(rd_n),
    .wr_n_o(wr_n), .bhe_n_o(bhe_n), .inst_o(inst)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  // external memory model: latch address in address clock, return bytes
  always @(negedge clk) if (ad_oe && rd_n && wr_n && bhe_n) lat <= ad_out;
  assign ad_in = (cfg_dyn && width_sel) ? {mb(lat | 16'h1), mb(lat & 16'hFFFE)}
                                        : {8'h00, mb(lat)};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] kind, input logic [15:0] addr,
                     input logic word, input logic [15:0] wd);
    @(negedge clk);
    req_kind = kind; req_addr = addr; req_word = word; req_wdata = wd;
    req_valid = 1'b1;
    ready = (ready_rise <= 0);
    done_t = -1; int_t = -1; n_ale = 0; n_alelo = 0; n_rd = 0; n_wr = 0;
    n_bhe = 0; n_inst = 0; n_aph = 0;
    wdat[0] = '0; wdat[1] = '0; aph_addr[0] = '0; aph_addr[1] = '0; rd_val = '0;
    for (int t = 1; t <= 120; t++) begin
      @(negedge clk);
      if (t == 1) req_valid = 1'b0;
      if (ale) n_ale++; else n_alelo++;
      if (!rd_n) n_rd++;
      if (!wr_n) n_wr++;
      if (!bhe_n) n_bhe++;
      if (inst) n_inst++;
      if (ad_oe && rd_n && wr_n && bhe_n) begin
        if (n_aph < 2) aph_addr[n_aph] = ad_out;
        n_aph++;
      end
      if ((!wr_n || !bhe_n) && n_aph >= 1 && n_aph <= 2) wdat[n_aph-1] = ad_out;
      if (int_sel && int_t < 0) int_t = t;
      if (done && done_t < 0) begin done_t = t; rd_val = rdata; end
      ready = (t >= ready_rise);
      if (done_t >= 0 || (int_t >= 0 && t >= int_t + 2)) break;
    end
  endtask

  task automatic t_reset;
    chk("R2 reset ale", ale, 0);
    chk("R4 reset rd_n", rd_n, 1);
    chk("R10 reset wr_n/bhe_n", {wr_n, bhe_n}, 2'b11);
    chk("R4 reset busy/done", {busy, done}, 0);
    chk("R12 reset inst", inst, 0);
  endtask

  task automatic t_route;
    run(2'd0, 16'h0050, 1'b1, 0);
    chk("R1 reg read internal", int_t, 1);
    chk("R1 reg read no strobe", n_rd + n_ale, 0);
    chk("R1 reg read no done", done_t, -1);
    run(2'd1, 16'h2100, 1'b1, 0);
    chk("R1 rom fetch internal", int_t, 1);
    run(2'd0, 16'h3FFF, 1'b0, 0);
    chk("R1 rom top internal", int_t, 1);
    rom_en = 1'b0;
    run(2'd1, 16'h2100, 1'b1, 0);
    chk("R1 rom disabled external", done_t, 5);
    chk("R1 rom disabled no int", int_t, -1);
    rom_en = 1'b1;
    run(2'd0, 16'h0100, 1'b1, 0);
    chk("R1 0100h external", done_t, 5);
  endtask

  task automatic t_ale_read;
    run(2'd0, 16'h4000, 1'b1, 0);
    chk("R2 ale clocks", n_ale, 1);
    chk("R2 address phase", aph_addr[0], 16'h4000);
    chk("R4 rd clocks", n_rd, 2);
    chk("R4 done clock", done_t, 5);
    chk("R9 word16 data", rd_val, {mb(16'h4001), mb(16'h4000)});
  endtask

  task automatic t_adv;
    @(negedge clk); cfg_adv = 1'b1;
    run(2'd0, 16'h4002, 1'b0, 0);
    chk("R3 adv low clocks", n_alelo, 3);
    chk("R3 adv done", done_t, 5);
    chk("R9 even byte16", rd_val, {8'h00, mb(16'h4002)});
    @(negedge clk); cfg_adv = 1'b0;
  endtask

  task automatic t_forced;
    cfg_wait = 2'd2;
    run(2'd0, 16'h4004, 1'b1, 0);
    chk("R5 forced done", done_t, 9);
    chk("R5 forced rd clocks", n_rd, 6);
    chk("R5 forced data", rd_val, {mb(16'h4005), mb(16'h4004)});
    cfg_wait = 2'd0;
  endtask

  task automatic t_ready;
    ready_rise = 4;
    run(2'd0, 16'h4006, 1'b1, 0);
    chk("R6 one wait done", done_t, 7);
    chk("R6 one wait rd", n_rd, 4);
    ready_rise = 6;
    run(2'd0, 16'h4008, 1'b1, 0);
    chk("R6 two waits done", done_t, 9);
    chk("R6 two waits data", rd_val, {mb(16'h4009), mb(16'h4008)});
    cfg_wait = 2'd1;
    run(2'd0, 16'h400A, 1'b1, 0);
    chk("R5 forced then ready", done_t, 9);
    cfg_wait = 2'd0; ready_rise = 0;
  endtask

  task automatic t_width;
    width_sel = 1'b0;
    run(2'd0, 16'h4011, 1'b1, 0);
    chk("R7 pin low 8-bit done", done_t, 9);
    chk("R8 two address phases", n_aph, 2);
    chk("R8 first even", aph_addr[0], 16'h4010);
    chk("R8 second odd", aph_addr[1], 16'h4011);
    chk("R8 assembled", rd_val, {mb(16'h4011), mb(16'h4010)});
    run(2'd0, 16'h4013, 1'b0, 0);
    chk("R9 byte8 data", rd_val, {8'h00, mb(16'h4013)});
    width_sel = 1'b1; cfg_dyn = 1'b0;
    run(2'd0, 16'h4014, 1'b1, 0);
    chk("R7 cfg off forces 8-bit", done_t, 9);
    cfg_dyn = 1'b1;
    run(2'd0, 16'h4003, 1'b0, 0);
    chk("R9 odd byte16", rd_val, {8'h00, mb(16'h4003)});
    chk("R7 pin high 16-bit done", done_t, 5);
  endtask

  task automatic t_wr_mode;
    cfg_split = 1'b0;
    run(2'd2, 16'h4020, 1'b1, 16'hBEEF);
    chk("R10 word wr", n_wr, 2);
    chk("R10 word bhe", n_bhe, 2);
    chk("R13 word data", wdat[0], 16'hBEEF);
    chk("R4 write done", done_t, 5);
    run(2'd2, 16'h4021, 1'b0, 16'h0077);
    chk("R10 odd byte bhe", n_bhe, 2);
    chk("R13 odd byte lanes", wdat[0], 16'h7777);
    run(2'd2, 16'h4022, 1'b0, 16'h0055);
    chk("R10 even byte no bhe", n_bhe, 0);
    chk("R10 even byte wr", n_wr, 2);
    width_sel = 1'b0;
    run(2'd2, 16'h4030, 1'b1, 16'h1234);
    chk("R10 8-bit word wr", n_wr, 4);
    chk("R10 8-bit word no bhe", n_bhe, 0);
    chk("R13 split low byte", wdat[0], 16'h3434);
    chk("R13 split high byte", wdat[1], 16'h1212);
    width_sel = 1'b1;
  endtask

  task automatic t_split;
    cfg_split = 1'b1;
    run(2'd2, 16'h4040, 1'b1, 16'hA55A);
    chk("R11 word both", {n_wr, n_bhe}, {32'd2, 32'd2});
    run(2'd2, 16'h4041, 1'b0, 16'h0011);
    chk("R11 odd byte wrl", n_wr, 0);
    chk("R11 odd byte wrh", n_bhe, 2);
    run(2'd2, 16'h4042, 1'b0, 16'h0022);
    chk("R11 even byte", {n_wr, n_bhe}, {32'd2, 32'd0});
    width_sel = 1'b0;
    run(2'd2, 16'h4050, 1'b1, 16'h6789);
    chk("R11 8-bit word", {n_wr, n_bhe}, {32'd2, 32'd2});
    width_sel = 1'b1; cfg_split = 1'b0;
  endtask

  task automatic t_fetch;
    run(2'd1, 16'h0050, 1'b1, 0);
    chk("R12 forced-external fetch inst", n_inst, 4);
    chk("R1 low fetch external", done_t, 5);
    run(2'd0, 16'h4060, 1'b1, 0);
    chk("R12 data read no inst", n_inst, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_route();
    t_ale_read();
    t_adv();
    t_forced();
    t_ready();
    t_width();
    t_wr_mode();
    t_split();
    t_fetch();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule